// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a set of BCD calendar registers (seconds, minutes, hours, weekday, day of month) and tests them against two programmable alarm settings. The time registers come from a separate counter that raises a one-cycle update pulse each second. The comparison runs only in the cycle that carries this pulse. Each alarm byte has an ignore bit in bit 7. When that bit is 1, the field drops out of the comparison, so the ignore bits together set how often the alarm repeats. The calendar byte of each alarm also holds a selector in bit 6. The selector picks whether the weekday or the day of the month is compared.

The first alarm compares seconds, minutes, hours and the calendar field. The second alarm has no seconds byte. It fires only when the seconds register reads 00, so it can fire at most once in any qualifying minute. On a match, each alarm gives a one-cycle hit pulse and sets a sticky flag. The host clears a flag by writing 0 to its bit. The host loads the alarm bytes through two byte-wide write ports.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, both hit pulses and both flags are 0, and every alarm byte reads 0x00 (all fields compared, date selector cleared).
- R2: Matching is evaluated only in a cycle with `tick` high. A hit pulse is high for exactly the one cycle after that tick cycle. A time that matches while `tick` is low produces no hit.
- R3: With bit 7 set in all four bytes of alarm 1, alarm 1 hits on every tick.
- R4: Alarm 1 byte selector: 0 is seconds, 1 is minutes, 2 is hours, 3 is the calendar byte. A field is compared only when bit 7 of its byte is 0. The alarm hits when every compared field is equal.
- R5: When the calendar byte's ignore bit is 0, bit 6 of that byte chooses the calendar field. A value of 1 compares bits [3:0] with the weekday, and 0 compares bits [5:0] with the day of month.
- R6: When the calendar byte's bit 7 is 1, its bit 6 has no effect on either alarm.
- R7: Alarm 2 hits only when bits [6:0] of the seconds input are 00. With bit 7 set in all three of its bytes, it hits on every tick whose seconds read 00.
- R8: Alarm 2 byte selector: 0 is minutes, 1 is hours, 2 is the calendar byte. A field is compared only when bit 7 of its byte is 0.
- R9: A hit sets its alarm's flag. A `flag_wr_en` cycle with 0 in the flag's bit of `flag_wr_data` clears it (bit 0 is alarm 1, bit 1 is alarm 2), and a 1 in that bit leaves it unchanged. A hit in the same cycle as a clear leaves the flag set.
- R10: An alarm 2 write with selector 3 changes no alarm state.
- R11: Ignore and selector bits are removed before comparing. Seconds and minutes compare bits [6:0], and hours compare bits [5:0], on both the alarm byte and the time input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Once-per-second update pulse from the time counter |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD in bits [5:0] |
| cur_wday | input | 8 | Current weekday, BCD in bits [3:0] |
| cur_mday | input | 8 | Current day of month, BCD |
| a1_wr_en | input | 1 | Alarm 1 byte write strobe |
| a1_wr_sel | input | 2 | Alarm 1 byte selector |
| a1_wr_data | input | 8 | Alarm 1 byte value |
| a2_wr_en | input | 1 | Alarm 2 byte write strobe |
| a2_wr_sel | input | 2 | Alarm 2 byte selector |
| a2_wr_data | input | 8 | Alarm 2 byte value |
| flag_wr_en | input | 1 | Flag write strobe |
| flag_wr_data | input | 2 | Flag write value; a 0 bit clears that flag |
| a1_hit | output | 1 | Alarm 1 match pulse |
| a2_hit | output | 1 | Alarm 2 match pulse |
| a1_flag | output | 1 | Alarm 1 sticky flag |
| a2_flag | output | 1 | Alarm 2 sticky flag |

## Verification
The bench drives a time whose hours and seconds inputs carry stray high bits. A design that failed to strip those bits would miss matches it should report. It sets the calendar selector while the calendar field is ignored, and it also selects weekday against a day of month that holds the same digits. Either mistake would show up as a wrong hit. It ticks alarm 2 at a matching minute with nonzero seconds, where a design lacking the zero-second rule would fire every second. It also issues a flag clear in the same cycle as a fresh hit, and writes alarm 2's unused selector; losing the flag or corrupting a byte would then show at the outputs.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 2;
  localparam int IGN_BIT  = 7;
  localparam int DSEL_BIT = 6;

  // Bits of a byte that take part in a comparison, per field kind
  localparam logic [BYTE_W-1:0] KEEP_SEC  = 8'h7F;
  localparam logic [BYTE_W-1:0] KEEP_MIN  = 8'h7F;
  localparam logic [BYTE_W-1:0] KEEP_HOUR = 8'h3F;
  localparam logic [BYTE_W-1:0] KEEP_MDAY = 8'h3F;
  localparam logic [BYTE_W-1:0] KEEP_WDAY = 8'h0F;

  typedef struct packed {
    logic [BYTE_W-1:0] mday;
    logic [BYTE_W-1:0] wday;
    logic [BYTE_W-1:0] hour;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] sec;
  } tod_t;

  typedef enum logic [1:0] {
    FK_SEC     = 2'd0,
    FK_MIN     = 2'd1,
    FK_HOUR    = 2'd2,
    FK_DAYDATE = 2'd3
  } fld_kind_e;

endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/tod_field_cmp.sv
module tod_field_cmp
  import tod_alarm_pkg::*;
#(
  parameter fld_kind_e KIND = FK_SEC
) (
  input  logic [BYTE_W-1:0] cfg_i,
  input  logic [BYTE_W-1:0] val_a_i,
  input  logic [BYTE_W-1:0] val_b_i,
  output logic              agree_o
);

  logic              use_b;
  logic [BYTE_W-1:0] keep;
  logic [BYTE_W-1:0] val;

  always_comb begin
    use_b = (KIND == FK_DAYDATE) && cfg_i[DSEL_BIT];
    val   = use_b ? val_b_i : val_a_i;
    case (KIND)
      FK_SEC:  keep = KEEP_SEC;
      FK_MIN:  keep = KEEP_MIN;
      FK_HOUR: keep = KEEP_HOUR;
      default: keep = use_b ? KEEP_WDAY : KEEP_MDAY;
    endcase
    agree_o = cfg_i[IGN_BIT] || ((cfg_i & keep) == (val & keep));
  end

endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int NFLD    = 4,
  parameter bit HAS_SEC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  tod_t              tod_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              clr_i,
  output logic              hit_o,
  output logic              flag_o
);

  localparam int FLD_OFS = HAS_SEC ? 0 : 1;

  logic [BYTE_W-1:0] cfg_q [NFLD];
  logic [BYTE_W-1:0] cfg_d [NFLD];
  logic              cfg_we;
  logic [NFLD-1:0]   agree;
  logic              sec_ok;
  logic              hit_d, hit_q;
  logic              flag_d, flag_q;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    localparam fld_kind_e K = fld_kind_e'(g + FLD_OFS);
    logic [BYTE_W-1:0] val_a;
    always_comb begin
      case (K)
        FK_SEC:  val_a = tod_i.sec;
        FK_MIN:  val_a = tod_i.min;
        FK_HOUR: val_a = tod_i.hour;
        default: val_a = tod_i.mday;
      endcase
    end
    tod_field_cmp #(.KIND(K)) u_cmp (
      .cfg_i   (cfg_q[g]),
      .val_a_i (val_a),
      .val_b_i (tod_i.wday),
      .agree_o (agree[g])
    );
  end

  // next state
  always_comb begin
    cfg_we = 1'b0;
    for (int k = 0; k < NFLD; k++) begin
      cfg_d[k] = cfg_q[k];
      if (wr_en_i && (wr_sel_i == SEL_W'(k))) begin
        cfg_d[k] = wr_data_i;
        cfg_we   = 1'b1;
      end
    end
    sec_ok = HAS_SEC ? 1'b1 : ((tod_i.sec & KEEP_SEC) == '0);
    hit_d  = tick_i && sec_ok && (&agree);
    flag_d = hit_d || (flag_q && !clr_i);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NFLD; k++) cfg_q[k] <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < NFLD; k++) cfg_q[k] <= cfg_d[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      flag_q <= flag_d;
    end
  end

  assign hit_o  = hit_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int A1_FIELDS   = 4,
  parameter int A2_FIELDS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_wday,
  input  logic [BYTE_W-1:0] cur_mday,
  input  logic              a1_wr_en,
  input  logic [SEL_W-1:0]  a1_wr_sel,
  input  logic [BYTE_W-1:0] a1_wr_data,
  input  logic              a2_wr_en,
  input  logic [SEL_W-1:0]  a2_wr_sel,
  input  logic [BYTE_W-1:0] a2_wr_data,
  input  logic              flag_wr_en,
  input  logic [1:0]        flag_wr_data,
  output logic              a1_hit,
  output logic              a2_hit,
  output logic              a1_flag,
  output logic              a2_flag
);

  logic rst_n_s;
  tod_t tod;
  logic [1:0] clr;

  tod_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    tod.sec  = cur_sec;
    tod.min  = cur_min;
    tod.hour = cur_hour;
    tod.wday = cur_wday;
    tod.mday = cur_mday;
    clr      = {2{flag_wr_en}} & ~flag_wr_data;
  end

  tod_alarm_unit #(.NFLD(A1_FIELDS), .HAS_SEC(1'b1)) u_al1 (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_i    (tick),
    .tod_i     (tod),
    .wr_en_i   (a1_wr_en),
    .wr_sel_i  (a1_wr_sel),
    .wr_data_i (a1_wr_data),
    .clr_i     (clr[0]),
    .hit_o     (a1_hit),
    .flag_o    (a1_flag)
  );

  tod_alarm_unit #(.NFLD(A2_FIELDS), .HAS_SEC(1'b0)) u_al2 (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_i    (tick),
    .tod_i     (tod),
    .wr_en_i   (a2_wr_en),
    .wr_sel_i  (a2_wr_sel),
    .wr_data_i (a2_wr_data),
    .clr_i     (clr[1]),
    .hit_o     (a2_hit),
    .flag_o    (a2_flag)
  );

endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [7:0] cur_sec,
  input logic       flag_wr_en,
  input logic [1:0] flag_wr_data,
  input logic       a1_hit,
  input logic       a2_hit,
  input logic       a1_flag,
  input logic       a2_flag
);

  // R2
  a1_hit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a1_hit |-> $past(tick));

  // R2
  a2_hit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a2_hit |-> $past(tick));

  // R7
  a2_zero_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a2_hit |-> ($past(cur_sec[6:0]) == 7'd0));

  // R9
  a1_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a1_hit |-> a1_flag);

  // R9
  a2_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a2_hit |-> a2_flag);

  // R9
  a1_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a1_flag) |-> a1_hit);

  // R9
  a1_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a1_flag) |-> $past(flag_wr_en && !flag_wr_data[0]));

  // R9
  a2_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a2_flag) |-> $past(flag_wr_en && !flag_wr_data[1]));

endmodule

bind tod_alarm_match tod_alarm_match_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tick),
  .cur_sec      (cur_sec),
  .flag_wr_en   (flag_wr_en),
  .flag_wr_data (flag_wr_data),
  .a1_hit       (a1_hit),
  .a2_hit       (a2_hit),
  .a1_flag      (a1_flag),
  .a2_flag      (a2_flag)
);

// File: tb/tod_alarm_match_tb.sv
module tod_alarm_match_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] cur_wday = 8'h01, cur_mday = 8'h01;
  logic       a1_wr_en = 1'b0, a2_wr_en = 1'b0, flag_wr_en = 1'b0;
  logic [1:0] a1_wr_sel = 2'd0, a2_wr_sel = 2'd0, flag_wr_data = 2'b11;
  logic [7:0] a1_wr_data = 8'h00, a2_wr_data = 8'h00;
  logic       a1_hit, a2_hit, a1_flag, a2_flag;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  tod_alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .cur_mday(cur_mday),
    .a1_wr_en(a1_wr_en), .a1_wr_sel(a1_wr_sel), .a1_wr_data(a1_wr_data),
    .a2_wr_en(a2_wr_en), .a2_wr_sel(a2_wr_sel), .a2_wr_data(a2_wr_data),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .a1_hit(a1_hit), .a2_hit(a2_hit), .a1_flag(a1_flag), .a2_flag(a2_flag)
  );

  // ---------------- reference model ----------------
  bit [7:0] m_a1 [4];
  bit [7:0] m_a2 [3];
  bit       m_h1, m_h2, m_f1, m_f2;
  int       rs_cnt = 0;

  function automatic bit fld_ok(bit [7:0] b, int kind);
    if (b[7]) return 1'b1;
    case (kind)
      0: return (b % 128) == (cur_sec % 128);
      1: return (b % 128) == (cur_min % 128);
      2: return (b % 64) == (cur_hour % 64);
      default:
        if (b[6]) return (b % 16) == (cur_wday % 16);
        else      return (b % 64) == (cur_mday % 64);
    endcase
  endfunction

  function automatic bit m_match1();
    return fld_ok(m_a1[0], 0) && fld_ok(m_a1[1], 1) &&
           fld_ok(m_a1[2], 2) && fld_ok(m_a1[3], 3);
  endfunction

  function automatic bit m_match2();
    return ((cur_sec % 128) == 0) && fld_ok(m_a2[0], 1) &&
           fld_ok(m_a2[1], 2) && fld_ok(m_a2[2], 3);
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 4; i++) m_a1[i] = 8'h00;
    for (int i = 0; i < 3; i++) m_a2[i] = 8'h00;
    m_h1 = 0; m_h2 = 0; m_f1 = 0; m_f2 = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rs_cnt = 0;
      m_clear();
    end else if (rs_cnt < 2) begin
      rs_cnt++;
      m_clear();
    end else begin
      bit h1, h2;
      h1 = tick && m_match1();
      h2 = tick && m_match2();
      m_f1 = h1 || (m_f1 && !(flag_wr_en && !flag_wr_data[0]));
      m_f2 = h2 || (m_f2 && !(flag_wr_en && !flag_wr_data[1]));
      m_h1 = h1;
      m_h2 = h2;
      if (a1_wr_en) m_a1[a1_wr_sel] = a1_wr_data;
      if (a2_wr_en && a2_wr_sel != 2'd3) m_a2[a2_wr_sel] = a2_wr_data;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "a1_hit(model)", a1_hit, m_h1);
      chk(cur_req, "a2_hit(model)", a2_hit, m_h2);
      chk(cur_req, "a1_flag(model)", a1_flag, m_f1);
      chk(cur_req, "a2_flag(model)", a2_flag, m_f2);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr1(int sel, bit [7:0] d);
    @(negedge clk);
    a1_wr_en = 1; a1_wr_sel = 2'(sel); a1_wr_data = d;
    @(negedge clk);
    a1_wr_en = 0;
  endtask

  task automatic wr2(int sel, bit [7:0] d);
    @(negedge clk);
    a2_wr_en = 1; a2_wr_sel = 2'(sel); a2_wr_data = d;
    @(negedge clk);
    a2_wr_en = 0;
  endtask

  task automatic fwr(bit [1:0] d);
    @(negedge clk);
    flag_wr_en = 1; flag_wr_data = d;
    @(negedge clk);
    flag_wr_en = 0; flag_wr_data = 2'b11;
  endtask

  task automatic set_t(bit [7:0] s, bit [7:0] m, bit [7:0] h, bit [7:0] wd, bit [7:0] md);
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = wd; cur_mday = md;
  endtask

  task automatic tk(string req, bit [7:0] s, bit [7:0] m, bit [7:0] h,
                    bit [7:0] wd, bit [7:0] md, logic e1, logic e2);
    @(negedge clk);
    set_t(s, m, h, wd, md);
    tick = 1;
    @(negedge clk);
    tick = 0;
    #1;
    chk(req, "a1_hit", a1_hit, e1);
    chk(req, "a2_hit", a2_hit, e2);
    @(negedge clk);
    #1;
    chk(req, "a1_hit one cycle", a1_hit, 1'b0);
    chk(req, "a2_hit one cycle", a2_hit, 1'b0);
  endtask

  function automatic bit [7:0] bcd(int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  int unsigned seed = 32'h1234_5678;
  function automatic int rnd(int n);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % n);
  endfunction

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "a1_flag in reset", a1_flag, 1'b0);
    chk("R1", "a2_flag in reset", a2_flag, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "a1_hit after reset", a1_hit, 1'b0);
    chk("R1", "a2_flag after reset", a2_flag, 1'b0);
    // reset bytes compare date 00: a valid date never matches
    tk("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0, 1'b0);

    // R3: everything ignored on alarm 1
    cur_req = "R3";
    for (int i = 0; i < 4; i++) wr1(i, 8'h80);
    tk("R3", 8'h12, 8'h34, 8'h05, 8'h03, 8'h15, 1'b1, 1'b0);
    tk("R3", 8'h59, 8'h01, 8'h23, 8'h07, 8'h31, 1'b1, 1'b0);
    fwr(2'b00);

    // R4: fields join the compare one by one
    cur_req = "R4";
    wr1(0, 8'h30);
    tk("R4", 8'h30, 8'h10, 8'h01, 8'h01, 8'h02, 1'b1, 1'b0);
    tk("R4", 8'h31, 8'h10, 8'h01, 8'h01, 8'h02, 1'b0, 1'b0);
    wr1(1, 8'h15);
    tk("R4", 8'h30, 8'h15, 8'h01, 8'h01, 8'h02, 1'b1, 1'b0);
    tk("R4", 8'h30, 8'h16, 8'h01, 8'h01, 8'h02, 1'b0, 1'b0);
    wr1(2, 8'h09);
    tk("R4", 8'h30, 8'h15, 8'h09, 8'h01, 8'h02, 1'b1, 1'b0);
    tk("R4", 8'h30, 8'h15, 8'h10, 8'h01, 8'h02, 1'b0, 1'b0);

    // R11: stray high bits on inputs are dropped
    cur_req = "R11";
    tk("R11", 8'hB0, 8'h95, 8'h49, 8'h01, 8'h02, 1'b1, 1'b0);
    tk("R11", 8'hB0, 8'h95, 8'h89, 8'h01, 8'h02, 1'b1, 1'b0);

    // R2: matching time without a tick
    cur_req = "R2";
    @(negedge clk);
    set_t(8'h30, 8'h15, 8'h09, 8'h01, 8'h02);
    repeat (3) @(negedge clk);
    #1;
    chk("R2", "a1_hit without tick", a1_hit, 1'b0);

    // R5: calendar selector
    cur_req = "R5";
    wr1(3, 8'h45);
    tk("R5", 8'h30, 8'h15, 8'h09, 8'h05, 8'h12, 1'b1, 1'b0);
    tk("R5", 8'h30, 8'h15, 8'h09, 8'h04, 8'h05, 1'b0, 1'b0);
    wr1(3, 8'h12);
    tk("R5", 8'h30, 8'h15, 8'h09, 8'h04, 8'h12, 1'b1, 1'b0);
    tk("R5", 8'h30, 8'h15, 8'h09, 8'h12, 8'h13, 1'b0, 1'b0);
    wr1(3, 8'h05);
    tk("R5", 8'h30, 8'h15, 8'h09, 8'h05, 8'h12, 1'b0, 1'b0);

    // R6: selector irrelevant while calendar ignored
    cur_req = "R6";
    wr1(3, 8'hC5);
    tk("R6", 8'h30, 8'h15, 8'h09, 8'h02, 8'h20, 1'b1, 1'b0);
    wr1(3, 8'h85);
    tk("R6", 8'h30, 8'h15, 8'h09, 8'h02, 8'h20, 1'b1, 1'b0);
    fwr(2'b00);

    // R7: alarm 2 every minute; alarm 1 parked on 59 s
    cur_req = "R7";
    wr1(0, 8'h59);
    for (int i = 0; i < 3; i++) wr2(i, 8'h80);
    tk("R7", 8'h00, 8'h22, 8'h03, 8'h01, 8'h02, 1'b0, 1'b1);
    tk("R7", 8'h01, 8'h22, 8'h03, 8'h01, 8'h02, 1'b0, 1'b0);
    tk("R7", 8'h80, 8'h23, 8'h03, 8'h01, 8'h02, 1'b0, 1'b1);

    // R8: alarm 2 field masks
    cur_req = "R8";
    wr2(0, 8'h15);
    tk("R8", 8'h00, 8'h15, 8'h03, 8'h01, 8'h02, 1'b0, 1'b1);
    tk("R8", 8'h00, 8'h16, 8'h03, 8'h01, 8'h02, 1'b0, 1'b0);
    tk("R7", 8'h01, 8'h15, 8'h03, 8'h01, 8'h02, 1'b0, 1'b0);
    wr2(1, 8'h09);
    tk("R8", 8'h00, 8'h15, 8'h09, 8'h01, 8'h02, 1'b0, 1'b1);
    tk("R8", 8'h00, 8'h15, 8'h08, 8'h01, 8'h02, 1'b0, 1'b0);
    wr2(2, 8'h47);
    tk("R8", 8'h00, 8'h15, 8'h09, 8'h07, 8'h02, 1'b0, 1'b1);
    tk("R8", 8'h00, 8'h15, 8'h09, 8'h06, 8'h07, 1'b0, 1'b0);

    // R10: unused alarm 2 selector
    cur_req = "R10";
    wr2(3, 8'h00);
    tk("R10", 8'h00, 8'h15, 8'h09, 8'h07, 8'h02, 1'b0, 1'b1);

    // R9: flag writes
    cur_req = "R9";
    fwr(2'b11);
    #1;
    chk("R9", "a2_flag kept by 1", a2_flag, 1'b1);
    fwr(2'b01);
    #1;
    chk("R9", "a2_flag cleared by 0", a2_flag, 1'b0);
    @(negedge clk);
    set_t(8'h00, 8'h15, 8'h09, 8'h07, 8'h02);
    tick = 1; flag_wr_en = 1; flag_wr_data = 2'b00;
    @(negedge clk);
    tick = 0; flag_wr_en = 0; flag_wr_data = 2'b11;
    #1;
    chk("R9", "a2_flag set wins over clear", a2_flag, 1'b1);
    chk("R9", "a1_flag cleared", a1_flag, 1'b0);

    // sweep against the model
    cur_req = "R4";
    for (int n = 0; n < 400; n++) begin
      if (n % 20 == 0) begin
        cur_req = (n % 40 == 0) ? "R4" : "R8";
        wr1(0, 8'(rnd(2) << 7) | bcd(rnd(3)));
        wr1(1, 8'(rnd(2) << 7) | bcd(rnd(2)));
        wr1(2, 8'(rnd(2) << 7) | bcd(rnd(2)));
        wr1(3, 8'(rnd(2) << 7) | 8'(rnd(2) << 6) | bcd(1 + rnd(2)));
        wr2(0, 8'(rnd(2) << 7) | bcd(rnd(2)));
        wr2(1, 8'(rnd(2) << 7) | bcd(rnd(2)));
        wr2(2, 8'(rnd(2) << 7) | 8'(rnd(2) << 6) | bcd(1 + rnd(2)));
      end
      @(negedge clk);
      set_t(bcd(rnd(3)), bcd(rnd(2)), bcd(rnd(2)), bcd(1 + rnd(2)), bcd(1 + rnd(2)));
      tick = 1;
      flag_wr_en = (rnd(4) == 0);
      flag_wr_data = 2'(rnd(4));
      @(negedge clk);
      tick = 0; flag_wr_en = 0; flag_wr_data = 2'b11;
    end
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule